// File: doc/BRIEF.md
# Half-Duplex Radio Mode and Channel Sequencer

This block sits between a host controller and a half-duplex narrowband radio module. It owns the module's power enable and its two active-low path selects, one for transmit and one for receive. It starts an external synthesizer loader whenever the channel changes, and it holds back a data-ready flag until the module has had time to settle. The host sends commands of three kinds: go to receive, go to transmit, and change channel. Commands use a valid/ready handshake. The sequencer holds one command at a time. `cmd_ready` stays low while a command is held and has not yet run. A held command waits until the current settling interval ends and then runs. While `cmd_ready` is low the host must keep `cmd_valid` and its payload steady, or withdraw them.

A channel change is only carried out with the receive path selected. If the request arrives in transmit, or before any path is selected, the sequencer first moves to receive and then programs the channel. The first channel programmed after power-up needs a long settling wait. Later changes need a shorter one. A plain switch between receive and transmit on an unchanged channel needs the shortest wait. The lock-detect input is read once, at a fixed interval after each channel load, and its value there sets or clears the lock-fault flag. Entering transmit also raises a preamble request for a set time, so the data path can send an alternating pattern.

All waits are counted in milliseconds. The millisecond tick comes from a clock prescaler set by `CLK_PER_MS`, and the prescaler restarts at the start of every settling interval. The RF path and the data framing are handled elsewhere.

Top module: `radio_mode_seq`

## Requirements
- R1: While reset is held, `txsel_n` and `rxsel_n` are high and `pwr_en`, `data_ready`, `load_start` and `preamble` are low. `pwr_en` goes high on the first clock after reset is released, while both selects are still high.
- R2: `txsel_n` and `rxsel_n` are never low together. In receive mode only `rxsel_n` is low. In transmit mode only `txsel_n` is low.
- R3: A channel command carries a channel index on `cmd_chan`. If transmit is selected (or no path is selected) when it runs, the sequencer first switches to receive in one cycle, without a load pulse. In the next cycle it raises `load_start` for exactly one cycle, with `load_chan` equal to the index and `rxsel_n` low.
- R4: For the first channel load after reset, `data_ready` rises exactly `FIRST_MS*CLK_PER_MS` cycles after the cycle in which `load_start` is high.
- R5: For every later channel load, `data_ready` rises exactly `CHAN_MS*CLK_PER_MS` cycles after `load_start`.
- R6: `lock_in` is read once per channel load, on the clock edge `LOCK_MS*CLK_PER_MS` cycles after `load_start`. From that edge on, `lock_fault` is 1 if the value read was low and 0 if it was high. Every new `load_start` clears `lock_fault`.
- R7: Changes on `lock_in` at any other time do not affect `lock_fault`.
- R8: A switch between receive and transmit with no channel change makes `data_ready` rise exactly `SWITCH_MS*CLK_PER_MS` cycles after the select lines change.
- R9: `preamble` rises when transmit is entered and stays high for exactly `PRE_MS*CLK_PER_MS` cycles. It drops at once if transmit is left earlier.
- R10: While a settling interval runs, an accepted command is held and `cmd_ready` is low. The held command runs on the clock after the interval ends.
- R11: A receive or transmit command for the mode that is already selected changes nothing: the selects stay as they are and `data_ready` stays high.
- R12: `data_ready` stays low until a channel has been loaded, even when a path is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command slot free |
| cmd_op | input | 2 | 1 receive, 2 transmit, 3 channel change, 0 ignored |
| cmd_chan | input | CHAN_W | Channel index for a channel change |
| lock_in | input | 1 | Synthesizer lock detect, high when locked |
| pwr_en | output | 1 | Module power enable |
| txsel_n | output | 1 | Transmit path select, active low |
| rxsel_n | output | 1 | Receive path select, active low |
| load_start | output | 1 | One-cycle start pulse for the synthesizer loader |
| load_chan | output | CHAN_W | Channel index for the loader |
| data_ready | output | 1 | Module settled, data may be exchanged |
| lock_fault | output | 1 | Lock detect was low at the last check |
| preamble | output | 1 | Preamble request after entering transmit |

## Verification
Two functions can fall in the same cycle. First, when the lock check interval equals the later-change wait, the single lock read and the end of settling happen on the same edge. The bench sets `LOCK_MS` equal to `CHAN_MS`, holds `lock_in` low only in a window around that edge, and expects `lock_fault` to set in the same sample where `data_ready` first rises. Second, a held transmit command must run on the clock right after a channel wait ends. The bench offers it while the wait runs, confirms that `cmd_ready` is low, and expects `data_ready` high for one sample and then the select swap on the next.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RX   = 2'd1,
    OP_TX   = 2'd2,
    OP_CHAN = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    M_OFF = 2'd0,
    M_RX  = 2'd1,
    M_TX  = 2'd2
  } mode_e;
endpackage

// File: rtl/ms_prescaler.sv
module ms_prescaler #(
  parameter int CLK_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

  logic [PW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (tick)         cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int MS_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic [MS_W-1:0] load_ms,
  input  logic            tick,
  output logic            busy
);
  logic [MS_W-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || abort)   left_q <= '0;
    else if (start)        left_q <= load_ms;
    else if (tick && busy) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/lock_sampler.sv
module lock_sampler #(
  parameter int MS_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            tick,
  input  logic [MS_W-1:0] check_ms,
  input  logic            lock_in,
  output logic            fault
);
  logic            armed_q;
  logic [MS_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= '0;
      fault   <= 1'b0;
    end else if (arm) begin
      armed_q <= 1'b1;
      seen_q  <= '0;
      fault   <= 1'b0;
    end else if (armed_q && tick) begin
      if (seen_q == check_ms - 1'b1) begin
        fault   <= !lock_in;
        armed_q <= 1'b0;
      end else begin
        seen_q <= seen_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
  import radio_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 1000,
  parameter int FIRST_MS   = 40,
  parameter int CHAN_MS    = 20,
  parameter int LOCK_MS    = 20,
  parameter int SWITCH_MS  = 5,
  parameter int PRE_MS     = 15,
  parameter int CHAN_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic              lock_in,
  output logic              pwr_en,
  output logic              txsel_n,
  output logic              rxsel_n,
  output logic              load_start,
  output logic [CHAN_W-1:0] load_chan,
  output logic              data_ready,
  output logic              lock_fault,
  output logic              preamble
);
  localparam int MAX_MS = (FIRST_MS > PRE_MS) ? FIRST_MS : PRE_MS;
  localparam int MS_W   = $clog2(MAX_MS + 1);

  mode_e             mode_q, mode_n;
  logic              pwr_q, chan_ok_q, first_done_q, load_q;
  logic [CHAN_W-1:0] load_chan_q;
  logic              pend_q;
  op_e               pend_op_q;
  logic [CHAN_W-1:0] pend_chan_q;

  logic            tick, busy, pre_busy;
  logic            exec, consume, start_t, do_load, enter_tx, leave_tx;
  logic [MS_W-1:0] wait_ms;

  assign exec = pend_q && !busy && pwr_q;

  always_comb begin
    mode_n   = mode_q;
    consume  = 1'b0;
    start_t  = 1'b0;
    do_load  = 1'b0;
    enter_tx = 1'b0;
    wait_ms  = MS_W'(SWITCH_MS);
    if (exec) begin
      unique case (pend_op_q)
        OP_RX: begin
          consume = 1'b1;
          if (mode_q != M_RX) begin
            mode_n  = M_RX;
            start_t = 1'b1;
          end
        end
        OP_TX: begin
          consume = 1'b1;
          if (mode_q != M_TX) begin
            mode_n   = M_TX;
            start_t  = 1'b1;
            enter_tx = 1'b1;
          end
        end
        OP_CHAN: begin
          if (mode_q != M_RX) begin
            mode_n = M_RX;
          end else begin
            consume = 1'b1;
            do_load = 1'b1;
            start_t = 1'b1;
            wait_ms = first_done_q ? MS_W'(CHAN_MS) : MS_W'(FIRST_MS);
          end
        end
        default: consume = 1'b1;
      endcase
    end
  end

  assign leave_tx = (mode_q == M_TX) && (mode_n != M_TX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= M_OFF;
      pwr_q        <= 1'b0;
      chan_ok_q    <= 1'b0;
      first_done_q <= 1'b0;
      load_q       <= 1'b0;
      load_chan_q  <= '0;
      pend_q       <= 1'b0;
      pend_op_q    <= OP_NONE;
      pend_chan_q  <= '0;
    end else begin
      pwr_q  <= 1'b1;
      mode_q <= mode_n;
      load_q <= do_load;
      if (do_load) begin
        load_chan_q  <= pend_chan_q;
        chan_ok_q    <= 1'b1;
        first_done_q <= 1'b1;
      end
      if (cmd_valid && cmd_ready) begin
        pend_q      <= 1'b1;
        pend_op_q   <= op_e'(cmd_op);
        pend_chan_q <= cmd_chan;
      end else if (consume) begin
        pend_q <= 1'b0;
      end
    end
  end

  ms_prescaler #(.CLK_PER_MS(CLK_PER_MS)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(start_t), .tick(tick)
  );

  settle_timer #(.MS_W(MS_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(start_t), .abort(1'b0),
    .load_ms(wait_ms), .tick(tick), .busy(busy)
  );

  settle_timer #(.MS_W(MS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .start(enter_tx), .abort(leave_tx),
    .load_ms(MS_W'(PRE_MS)), .tick(tick), .busy(pre_busy)
  );

  lock_sampler #(.MS_W(MS_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .arm(do_load), .tick(tick),
    .check_ms(MS_W'(LOCK_MS)), .lock_in(lock_in), .fault(lock_fault)
  );

  assign cmd_ready  = rst_n && !pend_q;
  assign pwr_en     = pwr_q;
  assign txsel_n    = (mode_q != M_TX);
  assign rxsel_n    = (mode_q != M_RX);
  assign load_start = load_q;
  assign load_chan  = load_chan_q;
  assign preamble   = pre_busy;
  assign data_ready = pwr_q && (mode_q != M_OFF) && chan_ok_q && !busy && !load_q;
endmodule

// File: rtl/radio_mode_seq_chk.sv
module radio_mode_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_en,
  input logic txsel_n,
  input logic rxsel_n,
  input logic load_start,
  input logic data_ready,
  input logic lock_fault,
  input logic preamble
);
  // R2
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txsel_n || rxsel_n));

  // R1
  power_after_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (txsel_n && rxsel_n));

  // R3
  load_in_receive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> (!rxsel_n && txsel_n));

  // R3
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !load_start);

  // R6
  load_clears_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> !lock_fault);

  // R9
  preamble_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preamble |-> !txsel_n);

  // R4
  no_ready_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> !data_ready);
endmodule

bind radio_mode_seq radio_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .txsel_n(txsel_n),
  .rxsel_n(rxsel_n), .load_start(load_start), .data_ready(data_ready),
  .lock_fault(lock_fault), .preamble(preamble)
);

// File: tb/radio_mode_seq_tb.sv
module radio_mode_seq_tb;
  localparam int P      = 4;
  localparam int FIRST  = 8;
  localparam int CHAN   = 4;
  localparam int LOCK   = 4;
  localparam int SWITCH = 2;
  localparam int PRE    = 3;
  localparam int CW     = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [CW-1:0] cmd_chan = '0;
  logic lock_in = 1'b0;
  logic cmd_ready, pwr_en, txsel_n, rxsel_n, load_start, data_ready, lock_fault, preamble;
  logic [CW-1:0] load_chan;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  radio_mode_seq #(
    .CLK_PER_MS(P), .FIRST_MS(FIRST), .CHAN_MS(CHAN), .LOCK_MS(LOCK),
    .SWITCH_MS(SWITCH), .PRE_MS(PRE), .CHAN_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .lock_in(lock_in), .pwr_en(pwr_en),
    .txsel_n(txsel_n), .rxsel_n(rxsel_n), .load_start(load_start),
    .load_chan(load_chan), .data_ready(data_ready), .lock_fault(lock_fault),
    .preamble(preamble)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [CW-1:0] ch);
    @(negedge clk);
    for (int i = 0; i < 500 && !cmd_ready; i++) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_chan  = ch;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_load();
    for (int i = 0; i < 500 && !load_start; i++) @(negedge clk);
  endtask

  // Counts cycles from load_start to data_ready while shaping lock_in:
  // held at good_lock in the window around the sample edge, toggling elsewhere.
  task automatic run_change(input logic good_lock, output int rdy_n, output int fault_at_ready);
    int n = 0;
    rdy_n = -1;
    fault_at_ready = -1;
    while (n < 200) begin
      lock_in = (n >= LOCK*P - 4 && n <= LOCK*P + 1) ? good_lock : n[0];
      @(negedge clk);
      n++;
      if (data_ready) begin
        rdy_n = n;
        fault_at_ready = int'(lock_fault);
        break;
      end
    end
    lock_in = 1'b1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rn, fa, txn, pren;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 txsel_n in reset", int'(txsel_n), 1);
    check("R1 rxsel_n in reset", int'(rxsel_n), 1);
    check("R1 pwr_en in reset", int'(pwr_en), 0);
    check("R1 data_ready in reset", int'(data_ready), 0);
    check("R1 preamble/load in reset", int'(preamble | load_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pwr_en after release", int'(pwr_en), 1);
    check("R1 selects high at power", int'(txsel_n & rxsel_n), 1);

    // R12 receive without channel: no ready
    send(2'd1, '0);
    @(negedge clk);
    check("R2 rx selects", int'({txsel_n, rxsel_n}), 2);
    repeat (20) @(negedge clk);
    check("R12 no ready before channel", int'(data_ready), 0);

    // R4 first change, lock glitches outside sample (R7)
    send(2'd3, 7'd5);
    wait_load();
    check("R3 load_chan first", int'(load_chan), 5);
    run_change(1'b1, rn, fa);
    check("R4 first wait cycles", rn, FIRST*P);
    check("R7 glitches ignored", int'(lock_fault), 0);

    // R5/R6 same-cycle: lock sample and end of settling coincide
    send(2'd3, 7'd6);
    wait_load();
    check("R6 fault cleared at load", int'(lock_fault), 0);
    run_change(1'b0, rn, fa);
    check("R5 later wait cycles", rn, CHAN*P);
    check("R6 fault set with ready", fa, 1);

    // R5 sweep over channels with good lock
    for (int ch = 0; ch < 128; ch += 17) begin
      send(2'd3, CW'(ch));
      wait_load();
      check("R3 load_chan sweep", int'(load_chan), ch);
      check("R6 fault cleared by load", int'(lock_fault), 0);
      run_change(1'b1, rn, fa);
      check("R5 sweep wait", rn, CHAN*P);
      check("R6 good lock", fa, 0);
    end

    // R8/R9 switch to transmit
    send(2'd2, '0);
    for (int i = 0; i < 50 && txsel_n; i++) @(negedge clk);
    check("R2 tx selects", int'({txsel_n, rxsel_n}), 1);
    check("R9 preamble on tx entry", int'(preamble), 1);
    txn = -1; pren = -1;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      if (txn < 0 && data_ready) txn = n;
      if (pren < 0 && !preamble) pren = n;
    end
    check("R8 switch wait", txn, SWITCH*P);
    check("R9 preamble length", pren, PRE*P);

    // R11 same-mode command
    send(2'd2, '0);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (!data_ready || txsel_n) begin
        check("R11 no effect", int'({data_ready, txsel_n}), 2);
        break;
      end
    end
    check("R11 still ready in tx", int'(data_ready & !txsel_n), 1);

    // R3 channel change from TX: rx first, load next cycle; R9 preamble drop on leave
    send(2'd2, '0);  // already tx; consumed
    repeat (3) @(negedge clk);
    send(2'd1, '0);  // back to rx
    repeat (12) @(negedge clk);
    send(2'd2, '0);  // tx again: preamble running
    for (int i = 0; i < 50 && txsel_n; i++) @(negedge clk);
    repeat (9) @(negedge clk);  // switch done, preamble still high
    check("R9 preamble still high", int'(preamble), 1);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_chan = 7'd99;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R3 rx before load", int'({txsel_n, rxsel_n, load_start}), 3'b100);
    check("R9 preamble dropped", int'(preamble), 0);
    @(negedge clk);
    check("R3 load after rx", int'(load_start), 1);
    check("R3 load_chan from tx", int'(load_chan), 99);

    // R10 hold during settling
    cmd_valid = 1'b1; cmd_op = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 ready low while held", int'(cmd_ready), 0);
    for (int n = 2; n <= CHAN*P + 1; n++) begin
      @(negedge clk);
      if (n == CHAN*P) check("R10 ready pulse before held", int'({data_ready, txsel_n}), 3);
      if (n == CHAN*P + 1) check("R10 held tx runs next", int'({data_ready, txsel_n}), 0);
    end
    check("R10 slot free after run", int'(cmd_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule